// File: doc/BRIEF.md
# Parity-Checked Link Word Receiver

This block sits behind the parallel output of a serial transceiver and turns its 20-bit frames into user link words. Each frame comes with a flag that marks it as data or control, a flag that names which half of a wide word it carries, an error strobe from the transceiver and a valid strobe. The block checks the frame's parity, qualifies the result as data or control, and reports errors on each word separately.

In narrow mode every data frame becomes one 16-bit user word. In wide mode two data frames, an upper half and a lower half, are joined into one 32-bit word, and the halves may arrive in either order. The output strobe fires only once both halves are in hand. A control frame carries a 12-bit user field, a test/normal selector and a single parity bit. It is delivered in either mode and leaves any pending half alone.

All outputs are registered. A word presented with the valid strobe at one rising edge appears on the outputs after that edge and stays there until the next word replaces it.

Top module: `lpk_rx`

## Requirements
- R1: With synchronous active-low reset sampled low, every output reads zero on the next cycle and any held half is dropped.
- R2: In narrow mode (`wideMode`=0), a data frame (`frmCtrl`=0) with `frmValid` gives `usrValid`=1 one cycle later, with `usrData[15:0]` equal to frame bits 15..0, `usrData[31:16]`=0 and `usrCtrl`=0.
- R3: For a data frame, frame bit 16+g is the odd parity of frame bits 4g+3..4g (g = 0..3). If any of the four groups has an even count of ones, `usrErr` is set on the resulting word.
- R4: `frmErr` high on a frame sets `usrErr` on the word that frame produces.
- R5: In wide mode, a data frame with `frmHalfHi`=1 supplies `usrData[31:16]` and one with `frmHalfHi`=0 supplies `usrData[15:0]`. `usrValid` rises only in the cycle after the second of the two halves, in either order.
- R6: In wide mode, the joined word has `usrErr` set if either half was bad under R3 or R4.
- R7: In wide mode, a half that arrives while the same half is already held replaces the earlier one, and `usrPairErr` pulses high for exactly one cycle after it. The word later emitted uses the newer half.
- R8: A control frame (`frmCtrl`=1) gives `usrValid`=1 and `usrCtrl`=1 one cycle later. `usrData[15:4]` equals frame bits 15..4 and all other data bits are zero. `usrTest`=1 when frame bit 17 is 0 and 0 when it is 1.
- R9: For a control frame, the count of ones in frame bits 16..0 must be odd, or `usrErr` is set. Frame bits 19..18 have no effect on any output.
- R10: A control frame arriving in wide mode while one half is held does not disturb that half. The next opposite half completes the word.
- R11: While `wideMode` is 0, any held half is dropped, so a lone half given after returning to wide mode does not complete a word.
- R12: In a cycle after an edge with no `frmValid`, `usrValid` and `usrPairErr` are 0 and `usrData`, `usrCtrl`, `usrTest` and `usrErr` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| frmIn | input | 20 | Frame from transceiver |
| frmCtrl | input | 1 | 1 = control frame, 0 = data frame |
| frmHalfHi | input | 1 | Wide mode: 1 = upper half, 0 = lower half |
| frmErr | input | 1 | Transceiver error for this frame |
| wideMode | input | 1 | 1 = 32-bit words from two halves, 0 = 16-bit words |
| frmValid | input | 1 | Frame present this cycle |
| usrData | output | 32 | User word |
| usrCtrl | output | 1 | User word is a control word |
| usrTest | output | 1 | Control word is a test word |
| usrValid | output | 1 | One-cycle strobe for a new user word |
| usrErr | output | 1 | Error flag of the current user word |
| usrPairErr | output | 1 | One-cycle strobe: a held half was replaced |

## Verification
Two functions can fall in the same cycle. Replacing a duplicate half and capturing an error both act on the held-half state: a bad half can replace a good one, or a good half can replace a bad one, and the joined word must carry the error state of the newer half only. The bench provokes this with fixed sequences and with long random runs that mix wide frames, control frames, parity faults and transceiver errors. The behavioural model judges `usrPairErr` and `usrErr` on every clock. The closing of a word whose held half was bad, while the closing half is clean, is also covered in both orders.

// File: rtl/lpk_pkg.sv
`timescale 1ns/1ps
package lpk_pkg;

  // Strobes from the control unit to the datapath, one frame at a time.
  typedef struct packed {
    logic ldHi;        // capture payload as upper half
    logic ldLo;        // capture payload as lower half
    logic emitNarrow;  // deliver a 16-bit data word
    logic emitCtrl;    // deliver a control word
    logic emitWide;    // join incoming half with the held one and deliver
  } lpkStb_t;

endpackage

// File: rtl/lpk_dp.sv
`timescale 1ns/1ps
module lpk_dp
  import lpk_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int GRP_N = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [GRP_W*GRP_N+GRP_N-1:0]  frmIn,
  input  logic                          frmCtrl,
  input  logic                          frmHalfHi,
  input  logic                          frmErr,
  input  lpkStb_t                       stb,
  output logic [2*GRP_W*GRP_N-1:0]      usrData,
  output logic                          usrCtrl,
  output logic                          usrTest,
  output logic                          usrValid,
  output logic                          usrErr
);

  localparam int HALF_W   = GRP_W * GRP_N;
  localparam int WORD_W   = 2 * HALF_W;
  localparam int TEST_POS = HALF_W + 1;

  logic [HALF_W-1:0] payload;
  logic [HALF_W-1:0] ctlPayload;
  logic [GRP_N-1:0]  grpOk;
  logic              dataParOk;
  logic              ctlParOk;
  logic              frameBad;

  assign payload    = frmIn[HALF_W-1:0];
  assign ctlPayload = {payload[HALF_W-1:GRP_W], {GRP_W{1'b0}}};

  // Odd parity per nibble group: group bits plus its check bit.
  genvar g;
  generate
    for (g = 0; g < GRP_N; g++) begin : gGrp
      assign grpOk[g] = ^{frmIn[HALF_W+g], frmIn[g*GRP_W +: GRP_W]};
    end
  endgenerate

  assign dataParOk = &grpOk;
  assign ctlParOk  = ^frmIn[HALF_W:0];
  assign frameBad  = frmErr | (frmCtrl ? ~ctlParOk : ~dataParOk);

  // Held halves and their error state.
  logic [HALF_W-1:0] hiReg, loReg;
  logic              hiBad, loBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
      hiBad <= 1'b0;
      loBad <= 1'b0;
    end else begin
      if (stb.ldHi) begin
        hiReg <= payload;
        hiBad <= frameBad;
      end
      if (stb.ldLo) begin
        loReg <= payload;
        loBad <= frameBad;
      end
    end
  end

  // Output selection.
  logic [WORD_W-1:0] nxtData;
  logic              nxtCtrl, nxtTest, nxtErr, anyEmit;

  always_comb begin
    nxtData = usrData;
    nxtCtrl = usrCtrl;
    nxtTest = usrTest;
    nxtErr  = usrErr;
    anyEmit = stb.emitNarrow | stb.emitCtrl | stb.emitWide;
    if (stb.emitCtrl) begin
      nxtData = {{HALF_W{1'b0}}, ctlPayload};
      nxtCtrl = 1'b1;
      nxtTest = ~frmIn[TEST_POS];
      nxtErr  = frameBad;
    end else if (stb.emitNarrow) begin
      nxtData = {{HALF_W{1'b0}}, payload};
      nxtCtrl = 1'b0;
      nxtTest = 1'b0;
      nxtErr  = frameBad;
    end else if (stb.emitWide) begin
      nxtCtrl = 1'b0;
      nxtTest = 1'b0;
      if (frmHalfHi) begin
        nxtData = {payload, loReg};
        nxtErr  = frameBad | loBad;
      end else begin
        nxtData = {hiReg, payload};
        nxtErr  = frameBad | hiBad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usrData  <= '0;
      usrCtrl  <= 1'b0;
      usrTest  <= 1'b0;
      usrErr   <= 1'b0;
      usrValid <= 1'b0;
    end else begin
      usrData  <= nxtData;
      usrCtrl  <= nxtCtrl;
      usrTest  <= nxtTest;
      usrErr   <= nxtErr;
      usrValid <= anyEmit;
    end
  end

endmodule

// File: rtl/lpk_ctl.sv
`timescale 1ns/1ps
module lpk_ctl
  import lpk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frmValid,
  input  logic    frmCtrl,
  input  logic    frmHalfHi,
  input  logic    wideMode,
  output lpkStb_t stb,
  output logic    usrPairErr
);

  logic hiHeld, loHeld;
  logic isData, wideData, dupHalf;

  assign isData   = frmValid & ~frmCtrl;
  assign wideData = isData & wideMode;

  always_comb begin
    stb            = '0;
    dupHalf        = 1'b0;
    stb.emitCtrl   = frmValid & frmCtrl;
    stb.emitNarrow = isData & ~wideMode;
    if (wideData) begin
      if (frmHalfHi) begin
        if (loHeld) begin
          stb.emitWide = 1'b1;
        end else begin
          stb.ldHi = 1'b1;
          dupHalf  = hiHeld;
        end
      end else begin
        if (hiHeld) begin
          stb.emitWide = 1'b1;
        end else begin
          stb.ldLo = 1'b1;
          dupHalf  = loHeld;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiHeld     <= 1'b0;
      loHeld     <= 1'b0;
      usrPairErr <= 1'b0;
    end else begin
      usrPairErr <= dupHalf;
      if (!wideMode) begin
        hiHeld <= 1'b0;
        loHeld <= 1'b0;
      end else if (stb.emitWide) begin
        hiHeld <= 1'b0;
        loHeld <= 1'b0;
      end else begin
        if (stb.ldHi) hiHeld <= 1'b1;
        if (stb.ldLo) loHeld <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpk_rx.sv
`timescale 1ns/1ps
module lpk_rx
  import lpk_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int GRP_N = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [GRP_W*GRP_N+GRP_N-1:0]  frmIn,
  input  logic                          frmCtrl,
  input  logic                          frmHalfHi,
  input  logic                          frmErr,
  input  logic                          wideMode,
  input  logic                          frmValid,
  output logic [2*GRP_W*GRP_N-1:0]      usrData,
  output logic                          usrCtrl,
  output logic                          usrTest,
  output logic                          usrValid,
  output logic                          usrErr,
  output logic                          usrPairErr
);

  lpkStb_t stb;

  lpk_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .frmValid   (frmValid),
    .frmCtrl    (frmCtrl),
    .frmHalfHi  (frmHalfHi),
    .wideMode   (wideMode),
    .stb        (stb),
    .usrPairErr (usrPairErr)
  );

  lpk_dp #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frmIn     (frmIn),
    .frmCtrl   (frmCtrl),
    .frmHalfHi (frmHalfHi),
    .frmErr    (frmErr),
    .stb       (stb),
    .usrData   (usrData),
    .usrCtrl   (usrCtrl),
    .usrTest   (usrTest),
    .usrValid  (usrValid),
    .usrErr    (usrErr)
  );

endmodule

// File: rtl/lpk_rx_chk.sv
`timescale 1ns/1ps
module lpk_rx_chk #(
  parameter int GRP_W = 4,
  parameter int GRP_N = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     frmCtrl,
  input logic                     wideMode,
  input logic                     frmValid,
  input logic [2*GRP_W*GRP_N-1:0] usrData,
  input logic                     usrCtrl,
  input logic                     usrValid,
  input logic                     usrPairErr
);

  localparam int HALF_W = GRP_W * GRP_N;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!usrValid && !usrPairErr && usrData == '0));

  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (usrValid && !usrCtrl && $past(!wideMode)) |-> usrData[2*HALF_W-1:HALF_W] == '0);

  assert_data_needs_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    (usrValid && !usrCtrl) |-> $past(frmValid && !frmCtrl));

  assert_pair_err_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    usrPairErr |-> $past(frmValid && wideMode && !frmCtrl));

  assert_ctrl_field_R8: assert property (@(posedge clk) disable iff (!rstN)
    (usrValid && usrCtrl) |->
      (usrData[GRP_W-1:0] == '0 && usrData[2*HALF_W-1:HALF_W] == '0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frmValid) |-> (!usrValid && !usrPairErr));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!usrValid && $past(rstN)) |-> $stable(usrData));

endmodule

bind lpk_rx lpk_rx_chk #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frmCtrl    (frmCtrl),
  .wideMode   (wideMode),
  .frmValid   (frmValid),
  .usrData    (usrData),
  .usrCtrl    (usrCtrl),
  .usrValid   (usrValid),
  .usrPairErr (usrPairErr)
);

// File: tb/sim_lpk_rx.sv
`timescale 1ns/1ps
module sim_lpk_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] frmIn = '0;
  logic        frmCtrl = 1'b0, frmHalfHi = 1'b0, frmErr = 1'b0;
  logic        wideMode = 1'b0, frmValid = 1'b0;
  logic [31:0] usrData;
  logic        usrCtrl, usrTest, usrValid, usrErr, usrPairErr;

  always #10 clk = ~clk;

  lpk_rx u0 (
    .clk(clk), .rstN(rstN), .frmIn(frmIn), .frmCtrl(frmCtrl),
    .frmHalfHi(frmHalfHi), .frmErr(frmErr), .wideMode(wideMode),
    .frmValid(frmValid), .usrData(usrData), .usrCtrl(usrCtrl),
    .usrTest(usrTest), .usrValid(usrValid), .usrErr(usrErr),
    .usrPairErr(usrPairErr)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  // Reference model state.
  bit        mHiHeld, mLoHeld, mHiBad, mLoBad;
  bit [15:0] mHi, mLo;
  bit [31:0] eData;
  bit        eCtrl, eTest, eValid, eErr, ePair;

  function automatic bit [19:0] mkData(input bit [15:0] pl, input bit [3:0] flip);
    bit [19:0] f;
    f[15:0] = pl;
    for (int g = 0; g < 4; g++) f[16+g] = (~^pl[4*g +: 4]) ^ flip[g];
    f[19:16] = f[19:16];
    return f;
  endfunction

  function automatic bit [19:0] mkCtl(input bit [11:0] fld, input bit normal,
                                      input bit flip, input bit [1:0] rsv);
    bit [19:0] f;
    f[15:4]  = fld;
    f[3:0]   = 4'hA;
    f[17]    = normal;
    f[16]    = (~^f[15:0]) ^ flip;
    f[19:18] = rsv;
    return f;
  endfunction

  task automatic cmpBit(input string tag, input string nm, input logic a, input bit e);
    if (a !== e) begin
      nBad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, a, e);
    end
  endtask

  task automatic compareAll(input string tag);
    nCmp++;
    if (usrData !== eData) begin
      nBad++;
      $display("FAIL %s usrData actual=%h expected=%h", tag, usrData, eData);
    end
    cmpBit(tag, "usrValid", usrValid, eValid);
    cmpBit(tag, "usrCtrl", usrCtrl, eCtrl);
    cmpBit(tag, "usrTest", usrTest, eTest);
    cmpBit(tag, "usrErr", usrErr, eErr);
    cmpBit(tag, "usrPairErr", usrPairErr, ePair);
  endtask

  // Called at a falling edge: drive, predict the next edge, compare after it.
  task automatic step(input bit r, input bit [19:0] f, input bit c, input bit h,
                      input bit e, input bit w, input bit v, input string tag);
    bit bad;
    int cnt;
    rstN = r; frmIn = f; frmCtrl = c; frmHalfHi = h; frmErr = e;
    wideMode = w; frmValid = v;
    eValid = 0; ePair = 0;
    if (c) begin
      cnt = 0;
      for (int i = 0; i <= 16; i++) cnt += f[i];
      bad = e || (cnt % 2 == 0);
    end else begin
      bad = e;
      for (int g = 0; g < 4; g++) begin
        cnt = f[16+g];
        for (int i = 0; i < 4; i++) cnt += f[4*g+i];
        if (cnt % 2 == 0) bad = 1;
      end
    end
    if (!r) begin
      mHiHeld = 0; mLoHeld = 0; mHiBad = 0; mLoBad = 0; mHi = 0; mLo = 0;
      eData = 0; eCtrl = 0; eTest = 0; eErr = 0;
    end else begin
      if (!w) begin mHiHeld = 0; mLoHeld = 0; end
      if (v) begin
        if (c) begin
          eValid = 1; eCtrl = 1; eTest = !f[17]; eErr = bad;
          eData = {16'h0, f[15:4], 4'h0};
        end else if (!w) begin
          eValid = 1; eCtrl = 0; eTest = 0; eErr = bad; eData = {16'h0, f[15:0]};
        end else if (h) begin
          if (mLoHeld) begin
            eValid = 1; eCtrl = 0; eTest = 0; eData = {f[15:0], mLo};
            eErr = bad || mLoBad; mLoHeld = 0;
          end else begin
            ePair = mHiHeld; mHi = f[15:0]; mHiBad = bad; mHiHeld = 1;
          end
        end else begin
          if (mHiHeld) begin
            eValid = 1; eCtrl = 0; eTest = 0; eData = {mHi, f[15:0]};
            eErr = bad || mHiBad; mHiHeld = 0;
          end else begin
            ePair = mLoHeld; mLo = f[15:0]; mLoBad = bad; mLoHeld = 1;
          end
        end
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input bit w, input string tag);
    step(1, 20'h0, 0, 0, 0, w, 0, tag);
  endtask

  task automatic dataN(input bit [15:0] pl, input bit [3:0] flip, input bit e, input string tag);
    step(1, mkData(pl, flip), 0, 0, e, 0, 1, tag);
  endtask

  task automatic half(input bit hi, input bit [15:0] pl, input bit [3:0] flip,
                      input bit e, input string tag);
    step(1, mkData(pl, flip), 0, hi, e, 1, 1, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state, with a frame offered during reset
    step(0, mkData(16'h1234, 0), 0, 0, 0, 0, 1, "R1");
    step(0, 20'h0, 0, 0, 0, 0, 0, "R1");
    idle(0, "R12");

    // R2: narrow words
    dataN(16'hBEEF, 4'h0, 0, "R2");
    dataN(16'h0000, 4'h0, 0, "R2");
    dataN(16'hFFFF, 4'h0, 0, "R2");
    idle(0, "R12");
    idle(0, "R12");
    // R3: each group faulted in turn
    for (int g = 0; g < 4; g++) dataN(16'h5A3C, 4'(1 << g), 0, "R3");
    dataN(16'h5A3C, 4'hF, 0, "R3");
    // R4: transceiver error on a clean frame
    dataN(16'h0F0F, 4'h0, 1, "R4");
    dataN(16'h0F0F, 4'h0, 0, "R4");

    // R8 / R9: control words
    step(1, mkCtl(12'hABC, 0, 0, 2'b00), 1, 0, 0, 0, 1, "R8");
    step(1, mkCtl(12'h123, 1, 0, 2'b00), 1, 0, 0, 0, 1, "R8");
    step(1, mkCtl(12'h123, 1, 1, 2'b00), 1, 0, 0, 0, 1, "R9");
    step(1, mkCtl(12'h7E1, 0, 0, 2'b11), 1, 0, 0, 0, 1, "R9");
    step(1, mkCtl(12'h7E1, 0, 0, 2'b10), 1, 0, 1, 0, 1, "R9");

    // R5: both orders, with idle gaps
    half(1, 16'hCAFE, 0, 0, "R5");
    idle(1, "R5");
    half(0, 16'hF00D, 0, 0, "R5");
    half(0, 16'h1111, 0, 0, "R5");
    half(1, 16'h2222, 0, 0, "R5");
    // R6: bad held half with clean closer, and clean held with bad closer
    half(1, 16'h3333, 4'h2, 0, "R6");
    half(0, 16'h4444, 0, 0, "R6");
    half(0, 16'h5555, 0, 1, "R6");
    half(1, 16'h6666, 0, 0, "R6");
    half(1, 16'h7777, 0, 0, "R6");
    half(0, 16'h8888, 4'h8, 0, "R6");
    // R7: duplicates; bad replaced by good and good by bad
    half(1, 16'h9999, 4'h1, 0, "R7");
    half(1, 16'hAAAA, 0, 0, "R7");
    half(0, 16'hBBBB, 0, 0, "R7");
    half(0, 16'hCCCC, 0, 0, "R7");
    half(0, 16'hDDDD, 0, 1, "R7");
    half(0, 16'hEEEE, 0, 0, "R7");
    half(1, 16'h1234, 0, 0, "R7");
    // R10: control word between halves
    half(1, 16'hA5A5, 0, 0, "R10");
    step(1, mkCtl(12'h456, 1, 0, 2'b01), 1, 0, 0, 1, 1, "R10");
    half(0, 16'h5A5A, 0, 0, "R10");
    // R11: leaving wide mode drops the held half
    half(1, 16'h7654, 0, 0, "R11");
    idle(0, "R11");
    half(0, 16'h3210, 0, 0, "R11");
    idle(1, "R11");
    half(1, 16'h0101, 0, 0, "R11");
    // R1: reset mid pair
    half(0, 16'h4242, 0, 0, "R1");
    step(0, 20'h0, 0, 0, 0, 1, 0, "R1");
    half(1, 16'h2424, 0, 0, "R1");
    half(0, 16'h1357, 0, 0, "R1");

    // Mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] rv;
      rv = $urandom;
      if (rv[3:0] == 4'h0)
        idle(rv[4], "R12");
      else if (rv[3:0] == 4'h1)
        step(1, mkCtl(rv[31:20], rv[5], rv[6] & rv[7], rv[9:8]), 1, 0, rv[10] & rv[11] & rv[12], rv[4], 1, "R10");
      else if (rv[3:0] == 4'h2)
        dataN(rv[31:16], (rv[7:6] == 2'b11) ? rv[11:8] : 4'h0, rv[12] & rv[13] & rv[14], "R3");
      else
        step(1, mkData(rv[31:16], (rv[7:5] == 3'b111) ? rv[11:8] : 4'h0), 0, rv[4],
             rv[12] & rv[13] & rv[14], !(rv[15:13] == 3'b000), 1, "R7");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule